// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block corrects colour for up to three display channels. Each channel owns three 256-entry, 8-bit tables: one for red, one for green and one for blue. All nine tables sit in one shared table store. A host loads the store through a small write-only register port. That port holds an address register, which carries an auto-increment flag and a force-power flag, a data register that writes one entry, and a control register with one gamma-enable bit per channel.

On the pixel side, each channel carries a 24-bit RGB word together with valid, hsync and vsync. When a channel's gamma enable is set, every colour component is replaced by the entry that it indexes in that channel's matching table. When the enable is clear, the word passes through unchanged. Either path adds exactly one register stage.

The table store has power only while some channel uses gamma or the force flag is set. A two-state machine tracks this. PWR_OFF moves to PWR_ON on the *wake* transition, taken one cycle after the need for power appears. PWR_ON moves back to PWR_OFF on the *sleep* transition, taken when the need goes away. The sleep transition discards every entry, so software must reload the tables after every power-down.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset, every channel output valid, hsync and vsync is 0. Auto-increment, force and all gamma enables are clear, the table address is 0, the store is in PWR_OFF, and every table entry reads as 0.
- R2: The entry for channel n, colour c (0 red, 1 green, 2 blue) and component value i sits at table address n*768 + c*256 + i. The RGB word carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: A host write at word offset 0 loads the table address from bits 11:0, auto-increment from bit 31 and force from bit 30. With auto-increment set, each write to offset 1 advances the address by one, and address 2303 wraps to 0.
- R4: With auto-increment clear, a write to offset 1 leaves the address unchanged, so successive data writes overwrite the same entry.
- R5: A write at offset 2 sets gamma enable of channel n from bit n. While it is set, each output component equals that channel's table entry indexed by the input component.
- R6: While a channel's gamma enable is clear, its output RGB equals its input RGB, whatever the tables hold.
- R7: Output RGB, valid, hsync and vsync of each channel follow the corresponding inputs exactly one clock later.
- R8: The store takes the wake transition one cycle after any gamma enable or force becomes set. While it is in PWR_OFF, data writes (offset 1, bits 7:0) are discarded, but the address still advances as configured.
- R9: The sleep transition, taken once no enable and no force remains, makes every entry read as 0 until it is rewritten.
- R10: With force set, clearing all gamma enables keeps the store powered and its contents survive.
- R11: When a data write and a pixel lookup hit the same entry in one cycle, the lookup returns the entry's previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Host write strobe |
| reg_ready | output | 1 | Host port accepts a write (always 1) |
| reg_offset | input | 2 | Word offset: 0 address, 1 data, 2 control |
| reg_wdata | input | 32 | Host write data |
| in_valid | input | 3 | Per-channel input pixel valid |
| in_hsync | input | 3 | Per-channel input line sync |
| in_vsync | input | 3 | Per-channel input frame sync |
| in_rgb | input | 72 | Per-channel RGB, channel n at bits 24n+23:24n |
| out_valid | output | 3 | Per-channel output pixel valid |
| out_hsync | output | 3 | Per-channel output line sync |
| out_vsync | output | 3 | Per-channel output frame sync |
| out_rgb | output | 72 | Per-channel corrected or bypassed RGB |

## Verification
A pixel presented between clock edges appears at the outputs after the next rising edge. The bench therefore drives each pixel at a falling edge and compares it at the following falling edge. In the latency sweep it also confirms that the outputs have not yet moved just after the drive. A register write takes effect at the rising edge after it is presented. The store wakes or sleeps one edge after that. For this reason the bench waits two idle cycles after every enable or force change before loading data or probing contents. The collision case presents a data write and a lookup of the same entry in the same cycle, then probes again one cycle later to see the new value.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
    typedef enum logic {PWR_OFF = 1'b0, PWR_ON = 1'b1} pwr_state_t;

    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_DATA = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam int AUTOINC_BIT = 31;
    localparam int FORCE_BIT   = 30;
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs
    import gamma_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CW     = 8,
    parameter int DEPTH  = 2304,
    parameter int AW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic [1:0]        reg_offset,
    input  logic [31:0]       reg_wdata,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [CW-1:0]     wr_data,
    output logic [NUM_CH-1:0] gamma_en,
    output logic              force_on
);
    logic          auto_q;
    logic [AW-1:0] addr_q;
    logic          unused_hi;

    assign unused_hi = ^reg_wdata[FORCE_BIT-1:AW];
    assign wr_en     = reg_valid && (reg_offset == OFS_DATA);
    assign wr_addr   = addr_q;
    assign wr_data   = reg_wdata[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q   <= 1'b0;
            force_on <= 1'b0;
            addr_q   <= '0;
            gamma_en <= '0;
        end else if (reg_valid) begin
            unique case (reg_offset)
                OFS_ADDR: begin
                    auto_q   <= reg_wdata[AUTOINC_BIT];
                    force_on <= reg_wdata[FORCE_BIT];
                    addr_q   <= reg_wdata[AW-1:0];
                end
                OFS_DATA: begin
                    if (auto_q)
                        addr_q <= (addr_q == AW'(DEPTH-1)) ? '0 : addr_q + 1'b1;
                end
                OFS_CTRL: gamma_en <= reg_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_offset == OFS_DATA && auto_q) |=>
        (addr_q == (($past(addr_q) == AW'(DEPTH-1)) ? '0 : $past(addr_q) + 1'b1))); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_offset == OFS_DATA && !auto_q) |=> $stable(addr_q)); // R4
endmodule

// File: rtl/gamma_ram.sv
module gamma_ram
    import gamma_pkg::*;
#(
    parameter int CW    = 8,
    parameter int DEPTH = 2304,
    parameter int AW    = 12,
    parameter int NRD   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              need,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CW-1:0]     wr_data,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*CW-1:0] rd_data,
    output logic [NRD-1:0]    rd_ok
);
    pwr_state_t       state_q, state_d;
    logic             pwr_on, sleep_now, wr_do;
    logic [CW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_OFF: if (need)  state_d = PWR_ON;
            PWR_ON:  if (!need) state_d = PWR_OFF;
            default: state_d = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        pwr_on    = (state_q == PWR_ON);
        sleep_now = pwr_on && !need;
        wr_do     = wr_en && pwr_on && (wr_addr < AW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (wr_do) mem_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         vld_q <= '0;
        else if (sleep_now) vld_q <= '0;
        else if (wr_do)     vld_q[wr_addr] <= 1'b1;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        always_ff @(posedge clk) begin
            rd_data[k*CW +: CW] <= mem_q[rd_addr[k*AW +: AW]];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_ok[k] <= 1'b0;
            else        rd_ok[k] <= vld_q[rd_addr[k*AW +: AW]];
        end
    end

    AST_SLEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_OFF && $past(state_q) == PWR_ON) |-> (vld_q == '0)); // R9
    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_OFF) |=> $stable(vld_q)); // R8
endmodule

// File: rtl/gamma_chan.sv
module gamma_chan #(
    parameter int CW     = 8,
    parameter int AW     = 12,
    parameter int CH_IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gamma_en,
    input  logic            in_valid,
    input  logic            in_hsync,
    input  logic            in_vsync,
    input  logic [3*CW-1:0] in_rgb,
    input  logic [3*CW-1:0] lut_data,
    input  logic [2:0]      lut_ok,
    output logic [3*AW-1:0] rd_addr,
    output logic            out_valid,
    output logic            out_hsync,
    output logic            out_vsync,
    output logic [3*CW-1:0] out_rgb
);
    localparam int TBL  = 1 << CW;
    localparam int BASE = CH_IDX * 3 * TBL;

    logic            en_q;
    logic [3*CW-1:0] rgb_q;

    for (genvar c = 0; c < 3; c++) begin : g_comp
        assign rd_addr[c*AW +: AW] = AW'(BASE + c*TBL) + AW'(in_rgb[(2-c)*CW +: CW]);
        assign out_rgb[(2-c)*CW +: CW] = en_q ? (lut_ok[c] ? lut_data[c*CW +: CW] : '0)
                                              : rgb_q[(2-c)*CW +: CW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            rgb_q     <= '0;
            out_valid <= 1'b0;
            out_hsync <= 1'b0;
            out_vsync <= 1'b0;
        end else begin
            en_q      <= gamma_en;
            rgb_q     <= in_rgb;
            out_valid <= in_valid;
            out_hsync <= in_hsync;
            out_vsync <= in_vsync;
        end
    end

    AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gamma_en) |=> (out_rgb == $past(in_rgb))); // R6
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
    parameter int NUM_CH = 3,
    parameter int CW     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_valid,
    output logic                   reg_ready,
    input  logic [1:0]             reg_offset,
    input  logic [31:0]            reg_wdata,
    input  logic [NUM_CH-1:0]      in_valid,
    input  logic [NUM_CH-1:0]      in_hsync,
    input  logic [NUM_CH-1:0]      in_vsync,
    input  logic [NUM_CH*3*CW-1:0] in_rgb,
    output logic [NUM_CH-1:0]      out_valid,
    output logic [NUM_CH-1:0]      out_hsync,
    output logic [NUM_CH-1:0]      out_vsync,
    output logic [NUM_CH*3*CW-1:0] out_rgb
);
    localparam int TBL   = 1 << CW;
    localparam int DEPTH = NUM_CH * 3 * TBL;
    localparam int AW    = $clog2(DEPTH);
    localparam int PIXW  = 3 * CW;
    localparam int NRD   = 3 * NUM_CH;

    logic              wr_en, force_on;
    logic [AW-1:0]     wr_addr;
    logic [CW-1:0]     wr_data;
    logic [NUM_CH-1:0] gamma_en;
    logic [NRD*AW-1:0] rd_addr;
    logic [NRD*CW-1:0] rd_data;
    logic [NRD-1:0]    rd_ok;

    assign reg_ready = 1'b1;

    gamma_regs #(.NUM_CH(NUM_CH), .CW(CW), .DEPTH(DEPTH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_offset(reg_offset),
        .reg_wdata(reg_wdata), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gamma_en(gamma_en), .force_on(force_on)
    );

    gamma_ram #(.CW(CW), .DEPTH(DEPTH), .AW(AW), .NRD(NRD)) u_ram (
        .clk(clk), .rst_n(rst_n), .need((|gamma_en) || force_on),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gamma_chan #(.CW(CW), .AW(AW), .CH_IDX(ch)) u_chan (
            .clk(clk), .rst_n(rst_n), .gamma_en(gamma_en[ch]),
            .in_valid(in_valid[ch]), .in_hsync(in_hsync[ch]), .in_vsync(in_vsync[ch]),
            .in_rgb(in_rgb[ch*PIXW +: PIXW]),
            .lut_data(rd_data[ch*PIXW +: PIXW]), .lut_ok(rd_ok[ch*3 +: 3]),
            .rd_addr(rd_addr[ch*3*AW +: 3*AW]),
            .out_valid(out_valid[ch]), .out_hsync(out_hsync[ch]), .out_vsync(out_vsync[ch]),
            .out_rgb(out_rgb[ch*PIXW +: PIXW])
        );
    end
endmodule

// File: tb/gamma_lut_top_bench.sv
module gamma_lut_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_valid = 1'b0;
    logic           reg_ready;
    logic [1:0]     reg_offset = '0;
    logic [31:0]    reg_wdata = '0;
    logic [NCH-1:0] in_valid = '0, in_hsync = '0, in_vsync = '0;
    logic [NCH*24-1:0] in_rgb = '0;
    logic [NCH-1:0] out_valid, out_hsync, out_vsync;
    logic [NCH*24-1:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_top u_gamma_lut_top (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
        .reg_offset(reg_offset), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_rgb(in_rgb),
        .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_rgb(out_rgb)
    );

    function automatic logic [7:0] tv(int ch, int c, int i);
        return 8'(i * (2*c + 3) + ch * 29 + c * 7 + 11);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] ofs, logic [31:0] d);
        reg_valid = 1'b1; reg_offset = ofs; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pix(int ch, logic [7:0] r, logic [7:0] g, logic [7:0] b,
                       logic [23:0] exp, string req);
        in_rgb[ch*24 +: 24] = {r, g, b};
        in_valid[ch] = 1'b1;
        @(negedge clk);
        chk(out_rgb[ch*24 +: 24] == exp && out_valid[ch], req,
            {7'd0, out_valid[ch], out_rgb[ch*24 +: 24]}, {8'h01, exp});
        in_valid[ch] = 1'b0;
    endtask

    initial begin
        logic [2:0] prev;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state of outputs
        chk(out_valid == '0 && out_hsync == '0 && out_vsync == '0, "R1",
            {23'd0, out_valid, out_hsync, out_vsync}, 32'd0);
        // R6: bypass sweep on every channel
        for (int ch = 0; ch < NCH; ch++)
            for (int v = 0; v < 256; v++)
                pix(ch, 8'(v), 8'(v) ^ 8'hA5, ~8'(v), {8'(v), 8'(v) ^ 8'hA5, ~8'(v)}, "R6");
        // R1: tables read as zero after reset
        reg_wr(2'd2, 32'h1);
        idle(2);
        pix(0, 8'd3, 8'd7, 8'd9, 24'h0, "R1");
        pix(1, 8'd3, 8'd7, 8'd9, 24'h030709, "R6");
        // R2 R3 R8: load all tables with auto-increment
        reg_wr(2'd0, 32'h8000_0000);
        for (int ch = 0; ch < NCH; ch++)
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < 256; i++)
                    reg_wr(2'd1, {24'd0, tv(ch, c, i)});
        reg_wr(2'd2, 32'h7);
        idle(1);
        // R2 R5: lookup sweep on every channel
        for (int ch = 0; ch < NCH; ch++)
            for (int v = 0; v < 256; v++)
                pix(ch, 8'(v), 8'(v) ^ 8'hA5, ~8'(v),
                    {tv(ch, 0, v), tv(ch, 1, int'(8'(v) ^ 8'hA5)), tv(ch, 2, int'(~8'(v)))}, "R2_R5");
        // R6: mixed enables
        reg_wr(2'd2, 32'h5);
        pix(1, 8'd10, 8'd20, 8'd30, 24'h0A141E, "R6");
        pix(0, 8'd10, 8'd20, 8'd30, {tv(0,0,10), tv(0,1,20), tv(0,2,30)}, "R5");
        reg_wr(2'd2, 32'h7);
        // R4: no auto-increment
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, 32'h11);
        reg_wr(2'd1, 32'h22);
        pix(0, 8'd0, 8'd0, 8'd0, {8'h22, tv(0,1,0), tv(0,2,0)}, "R4");
        pix(0, 8'd1, 8'd0, 8'd0, {tv(0,0,1), tv(0,1,0), tv(0,2,0)}, "R4");
        // R3: wrap from the last entry
        reg_wr(2'd0, 32'h8000_0000 | 32'd2303);
        reg_wr(2'd1, 32'h99);
        reg_wr(2'd1, 32'h77);
        pix(2, 8'd0, 8'd0, 8'd255, {tv(2,0,0), tv(2,1,0), 8'h99}, "R3");
        pix(0, 8'd0, 8'd0, 8'd0, {8'h77, tv(0,1,0), tv(0,2,0)}, "R3");
        // R11: same-cycle write and lookup
        reg_wr(2'd0, 32'd1);
        reg_valid = 1'b1; reg_offset = 2'd1; reg_wdata = 32'h5A;
        pix(0, 8'd1, 8'd0, 8'd0, {tv(0,0,1), tv(0,1,0), tv(0,2,0)}, "R11");
        reg_valid = 1'b0;
        pix(0, 8'd1, 8'd0, 8'd0, {8'h5A, tv(0,1,0), tv(0,2,0)}, "R11");
        // R10: force keeps contents
        reg_wr(2'd0, 32'h4000_0000);
        reg_wr(2'd2, 32'h0);
        idle(2);
        reg_wr(2'd2, 32'h1);
        idle(2);
        pix(0, 8'd1, 8'd0, 8'd0, {8'h5A, tv(0,1,0), tv(0,2,0)}, "R10");
        pix(0, 8'd0, 8'd0, 8'd0, {8'h77, tv(0,1,0), tv(0,2,0)}, "R10");
        // R9: sleep discards contents
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd2, 32'h0);
        idle(2);
        reg_wr(2'd2, 32'h1);
        idle(2);
        pix(0, 8'd1, 8'd0, 8'd0, 24'h0, "R9");
        pix(2, 8'd0, 8'd0, 8'd255, {8'd0, 8'd0, 8'd255}, "R6");
        // R8: writes while unpowered are dropped, address still advances
        reg_wr(2'd2, 32'h0);
        idle(2);
        reg_wr(2'd0, 32'h8000_0000);
        reg_wr(2'd1, 32'h33);
        reg_wr(2'd2, 32'h1);
        idle(2);
        reg_wr(2'd1, 32'h44);
        pix(0, 8'd0, 8'd0, 8'd0, 24'h0, "R8");
        pix(0, 8'd1, 8'd0, 8'd0, {8'h44, 8'd0, 8'd0}, "R8");
        // R7: valid/hsync/vsync follow one cycle later
        prev = 3'b000;
        for (int i = 0; i < 8; i++) begin
            in_valid[1] = i[0]; in_hsync[1] = i[1]; in_vsync[1] = i[2];
            #1;
            chk({out_vsync[1], out_hsync[1], out_valid[1]} == prev, "R7",
                {29'd0, out_vsync[1], out_hsync[1], out_valid[1]}, {29'd0, prev});
            @(negedge clk);
            chk({out_vsync[1], out_hsync[1], out_valid[1]} == 3'(i), "R7",
                {29'd0, out_vsync[1], out_hsync[1], out_valid[1]}, 32'(i));
            prev = 3'(i);
        end
        in_valid = '0; in_hsync = '0; in_vsync = '0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule